// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash device. It decides whether a program or erase operation that was already launched has finished. After a start pulse it reads the device status word again and again over a simple read-request / read-acknowledge handshake. It compares the toggle bit (bit 6) between consecutive reads. When the toggle bit keeps changing, it also looks at the exceeded-timing flag (bit 5). It ends with exactly one result pulse: success, failure or abandoned. A failure also pulses a reset-command request, which the surrounding command logic turns into the device reset write.

When bit 6 is still changing and bit 5 has risen, the block does not give up at once. The toggling may have stopped at the same moment the flag rose, so the block takes two fresh reads and decides from those. An abort input drops all stored samples, so a later start always begins from a first read. A parameterised read budget ends polling with a failure if the device never settles, so a stuck bus cannot hang the poller. The status word width is a parameter that covers 8-bit and 16-bit data paths.

Top module: `toggle_poller`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `rd_req_o`, `done_ok_o`, `done_fail_o`, `abandoned_o` and `reset_cmd_o` are low until a start is taken.
- R2: A `start_i` pulse while idle raises `busy_o` and `rd_req_o` on the next cycle, and polling begins with a first read. A `start_i` while busy has no effect on the reads taken or on the result.
- R3: A read completes only in a cycle where `rd_req_o` and `rd_ack_i` are both high, and `rd_data_i` is sampled only then. `rd_req_o` stays high through cycles without an acknowledge.
- R4: If bit 6 is equal on two consecutive completed reads, `done_ok_o` pulses in the cycle after the second read completes, and `busy_o` is low in that same cycle.
- R5: If bit 6 differs between two consecutive reads and bit 5 of the later read is 0, polling continues. Each new read is compared with the read just before it.
- R6: If bit 6 differs and bit 5 of the later read is 1, two fresh reads follow. If bit 6 is equal on them, the block reports success. If it differs, `done_fail_o` and `reset_cmd_o` pulse together.
- R7: When the MAX_POLLS-th read of one poll ends without success, the block reports failure with `reset_cmd_o`. A success found on that read is still reported as success.
- R8: `abort_i` while busy ends polling: `abandoned_o` pulses on the next cycle with `busy_o` low, and every stored sample and the read count are discarded. `abort_i` while idle produces no pulse.
- R9: Status bits other than bits 6 and 5 do not affect the result. Each result output is a one-cycle pulse, and at most one of the three is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin polling (taken only while idle) |
| abort_i | input | 1 | Abandon polling and drop stored samples |
| rd_req_o | output | 1 | Status read requested |
| rd_ack_i | input | 1 | Read data valid this cycle |
| rd_data_i | input | DATA_W | Status word from the device |
| busy_o | output | 1 | Polling in progress |
| done_ok_o | output | 1 | Operation completed (pulse) |
| done_fail_o | output | 1 | Operation failed or budget exhausted (pulse) |
| abandoned_o | output | 1 | Polling aborted (pulse) |
| reset_cmd_o | output | 1 | Request a device reset-command write (pulse, with failure) |

## Verification
The bench builds the poller with a 16-bit status word and a budget of six reads. With a budget this small, a read sequence a few words long can reach the exhausted-budget path. It can reach it both in the middle of a plain toggle run and on the first read of a re-check, and it can also reach the case where the last allowed read finds the toggle bit settled. The unused bits of the 16-bit word are filled with changing patterns, so any dependence on bits other than 6 and 5 would show up. The bench also applies stalled acknowledges and stray start pulses during polling.

// File: rtl/tp_pkg.sv
package tp_pkg;

    localparam int TGL_POS = 6;
    localparam int TMO_POS = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_NEXT,
        ST_RECHK_A,
        ST_RECHK_B
    } tp_state_e;

    typedef struct packed {
        tp_state_e state;
        logic      prev_tgl;
        logic      ok;
        logic      fail;
        logic      abandon;
    } tp_regs_t;

endpackage

// File: rtl/tp_status_decode.sv
module tp_status_decode #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic              prev_tgl_i,
    output logic              tgl_o,
    output logic              tmo_o,
    output logic              toggled_o
);
    import tp_pkg::*;

    logic unused_bits;

    always_comb begin
        tgl_o       = word_i[TGL_POS];
        tmo_o       = word_i[TMO_POS];
        toggled_o   = word_i[TGL_POS] ^ prev_tgl_i;
        unused_bits = ^{word_i[DATA_W-1:TGL_POS+1], word_i[TMO_POS-1:0]};
    end

endmodule

// File: rtl/tp_poll_budget.sv
module tp_poll_budget #(
    parameter int MAX_POLLS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic count_i,
    output logic last_o
);
    localparam int CNT_W = $clog2(MAX_POLLS + 1);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(MAX_POLLS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (count_i && cnt_q <= LAST_VAL) begin
            cnt_d = cnt_q + 1'b1;
        end
        last_o = (cnt_q == LAST_VAL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R7: the read count never runs past the budget
    a_r7_budget_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_POLLS));

    // R7: a clear always restarts the count from zero
    a_r7_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/toggle_poller.sv
module toggle_poller #(
    parameter int DATA_W    = 16,
    parameter int MAX_POLLS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    output logic              rd_req_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_ok_o,
    output logic              done_fail_o,
    output logic              abandoned_o,
    output logic              reset_cmd_o
);
    import tp_pkg::*;

    tp_regs_t r_d, r_q;
    logic     tgl, tmo, toggled;
    logic     cnt_clear, cnt_en, cnt_last;
    logic     rd_done;

    tp_status_decode #(.DATA_W(DATA_W)) i_decode (
        .word_i     (rd_data_i),
        .prev_tgl_i (r_q.prev_tgl),
        .tgl_o      (tgl),
        .tmo_o      (tmo),
        .toggled_o  (toggled)
    );

    tp_poll_budget #(.MAX_POLLS(MAX_POLLS)) i_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cnt_clear),
        .count_i (cnt_en),
        .last_o  (cnt_last)
    );

    always_comb begin
        r_d         = r_q;
        r_d.ok      = 1'b0;
        r_d.fail    = 1'b0;
        r_d.abandon = 1'b0;
        cnt_clear   = 1'b0;
        cnt_en      = 1'b0;
        rd_done     = (r_q.state != ST_IDLE) && rd_ack_i;

        if (r_q.state == ST_IDLE) begin
            if (start_i) begin
                r_d.state    = ST_FIRST;
                r_d.prev_tgl = 1'b0;
                cnt_clear    = 1'b1;
            end
        end else if (abort_i) begin
            r_d.state    = ST_IDLE;
            r_d.prev_tgl = 1'b0;
            r_d.abandon  = 1'b1;
            cnt_clear    = 1'b1;
        end else if (rd_done) begin
            cnt_en = 1'b1;
            unique case (r_q.state)
                ST_FIRST, ST_RECHK_A: begin
                    r_d.prev_tgl = tgl;
                    if (cnt_last) begin
                        r_d.state = ST_IDLE;
                        r_d.fail  = 1'b1;
                    end else begin
                        r_d.state = (r_q.state == ST_FIRST) ? ST_NEXT : ST_RECHK_B;
                    end
                end
                ST_NEXT: begin
                    if (!toggled) begin
                        r_d.state = ST_IDLE;
                        r_d.ok    = 1'b1;
                    end else if (cnt_last) begin
                        r_d.state = ST_IDLE;
                        r_d.fail  = 1'b1;
                    end else if (tmo) begin
                        r_d.state = ST_RECHK_A;
                    end else begin
                        r_d.prev_tgl = tgl;
                    end
                end
                ST_RECHK_B: begin
                    r_d.state = ST_IDLE;
                    r_d.ok    = !toggled;
                    r_d.fail  = toggled;
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, prev_tgl: 1'b0, ok: 1'b0, fail: 1'b0, abandon: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy_o      = (r_q.state != ST_IDLE);
        rd_req_o    = busy_o;
        done_ok_o   = r_q.ok;
        done_fail_o = r_q.fail;
        abandoned_o = r_q.abandon;
        reset_cmd_o = r_q.fail;
    end

    // R9: never more than one result in a cycle
    a_r9_single_result: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_ok_o, done_fail_o, abandoned_o}));

    // R9: a result lasts one cycle
    a_r9_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok_o || done_fail_o || abandoned_o) |=> !(done_ok_o || done_fail_o || abandoned_o));

    // R4: a completion result leaves the block idle
    a_r4_idle_on_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok_o || done_fail_o) |-> !busy_o);

    // R2: start while idle enters polling
    a_r2_start_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && rd_req_o));

    // R3: the request holds until a read completes
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i && !abort_i) |=> rd_req_o);

    // R8: abort while busy gives an abandoned pulse and idle
    a_r8_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && abort_i) |=> (abandoned_o && !busy_o));

    // R8: no abandoned pulse without a preceding abort
    a_r8_abandon_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!abort_i) |=> !abandoned_o);

endmodule

// File: tb/test_toggle_poller.sv
module test_toggle_poller;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int MAX_POLLS  = 6;
    localparam int NVEC       = 10;

    // vector: {expected result (1 ok, 2 fail), read count, 8 words of {bit6,bit5}, first word at MSB}
    localparam logic [21:0] VECS [NVEC] = '{
        {2'd1, 4'd2, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00},
        {2'd1, 4'd2, 2'b10, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00},
        {2'd1, 4'd3, 2'b00, 2'b10, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00},
        {2'd1, 4'd4, 2'b00, 2'b11, 2'b01, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00},
        {2'd2, 4'd4, 2'b00, 2'b11, 2'b01, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00},
        {2'd2, 4'd6, 2'b00, 2'b10, 2'b00, 2'b10, 2'b00, 2'b10, 2'b00, 2'b00},
        {2'd1, 4'd5, 2'b00, 2'b10, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00},
        {2'd1, 4'd6, 2'b00, 2'b10, 2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00},
        {2'd2, 4'd6, 2'b00, 2'b10, 2'b00, 2'b10, 2'b01, 2'b00, 2'b00, 2'b00},
        {2'd1, 4'd2, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              abort_i = 1'b0;
    logic              rd_ack_i = 1'b0;
    logic [DATA_W-1:0] rd_data_i = '0;
    logic              rd_req_o, busy_o, done_ok_o, done_fail_o, abandoned_o, reset_cmd_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    toggle_poller #(.DATA_W(DATA_W), .MAX_POLLS(MAX_POLLS)) i_toggle_poller (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .abort_i     (abort_i),
        .rd_req_o    (rd_req_o),
        .rd_ack_i    (rd_ack_i),
        .rd_data_i   (rd_data_i),
        .busy_o      (busy_o),
        .done_ok_o   (done_ok_o),
        .done_fail_o (done_fail_o),
        .abandoned_o (abandoned_o),
        .reset_cmd_o (reset_cmd_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected under 20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string tag_of(input int v);
        case (v)
            0, 1, 9: return "R4";
            2:       return "R5";
            3, 4, 6: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Runs one poll; stall inserts an idle cycle before each acknowledge,
    // mid_start pulses start during every read of the poll.
    task automatic run_poll(input logic [15:0] w, input int n, input int seed,
                            input bit stall, input bit mid_start,
                            output int res, output int reads);
        int  idx = 0;
        bit  hold = stall;
        logic [1:0] code;
        res = 0;
        reads = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int cyc = 0; cyc < 60 && res == 0; cyc++) begin
            if (done_ok_o) res = 1;
            else if (done_fail_o) res = 2;
            else if (abandoned_o) res = 3;
            rd_ack_i = 1'b0;
            start_i  = 1'b0;
            if (res != 0) begin
                chk(reset_cmd_o == (res == 2), "R6", int'(reset_cmd_o), int'(res == 2));
            end else if (rd_req_o) begin
                if (hold) begin
                    hold = 1'b0;
                end else begin
                    code = (idx < 8) ? w[15 - 2*idx -: 2] : 2'b00;
                    rd_data_i = DATA_W'(16'h9C3A ^ (seed * 16'h1357) ^ (idx * 16'h2468));
                    rd_data_i[6] = code[1];
                    rd_data_i[5] = code[0];
                    rd_ack_i = 1'b1;
                    start_i  = mid_start;
                    idx++;
                    reads++;
                    hold = stall;
                end
                @(negedge clk);
            end else begin
                @(negedge clk);
            end
        end
        rd_ack_i = 1'b0;
        start_i  = 1'b0;
        @(negedge clk);
        chk(!(done_ok_o || done_fail_o || abandoned_o), "R9", int'({done_ok_o, done_fail_o, abandoned_o}), 0);
    endtask

    initial begin
        int res, reads;

        // R1: reset state
        #(CLK_PERIOD * 2 + 3);
        chk(!busy_o && !rd_req_o, "R1", int'({busy_o, rd_req_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!(busy_o || rd_req_o || done_ok_o || done_fail_o || abandoned_o || reset_cmd_o), "R1",
            int'({busy_o, rd_req_o, done_ok_o, done_fail_o, abandoned_o, reset_cmd_o}), 0);

        // R2: start raises busy and the request on the next cycle
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && rd_req_o, "R2", int'({busy_o, rd_req_o}), 3);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk(abandoned_o && !busy_o, "R8", int'({abandoned_o, busy_o}), 2);

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            run_poll(VECS[v][15:0], int'(VECS[v][19:16]), v, 1'b0, 1'b0, res, reads);
            chk(res == int'(VECS[v][21:20]), tag_of(v), res, int'(VECS[v][21:20]));
            chk(reads == int'(VECS[v][19:16]), tag_of(v), reads, int'(VECS[v][19:16]));
        end

        // R3: stalled acknowledges leave the outcome unchanged
        run_poll({2'b00, 2'b11, 2'b01, 2'b11, 8'h00}, 4, 11, 1'b1, 1'b0, res, reads);
        chk(res == 2 && reads == 4, "R3", res * 10 + reads, 24);

        // R2: start pulses while busy are ignored
        run_poll({2'b00, 2'b10, 2'b10, 10'h000}, 3, 12, 1'b0, 1'b1, res, reads);
        chk(res == 1 && reads == 3, "R2", res * 10 + reads, 13);

        // R8: abort after one read, then a fresh poll must not reuse the old sample
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        rd_data_i = '0;
        rd_ack_i = 1'b1;
        @(negedge clk);
        rd_ack_i = 1'b0;
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk(abandoned_o && !busy_o && !done_fail_o, "R8", int'({abandoned_o, busy_o, done_fail_o}), 4);
        run_poll({2'b11, 2'b11, 12'h000}, 2, 13, 1'b0, 1'b0, res, reads);
        chk(res == 1 && reads == 2, "R8", res * 10 + reads, 12);

        // R8: abort while idle gives no pulse
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk(!abandoned_o && !busy_o, "R8", int'({abandoned_o, busy_o}), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule